// File: doc/BRIEF.md
# Lane Pair Width Mode Controller

This block decides how two serial ports that share one MAC use their lanes. The even port of the pair can run alone on four lanes, with the odd port unused and powered down. Otherwise both ports run as independent single-lane ports: the even port on lane A and the odd port on lane B.

After reset the block waits for a board strap to hold one level for a set number of consecutive clock cycles. It then latches that level as the starting mode and keeps it as a read-only width status. Software can then choose the other mode through a register write. The write is accepted only while both ports are already powered down, and the new mode takes effect at the write that powers them back up.

While the even port is in four-lane mode, lane faults make it fall back to a single lane: lane A if that lane is healthy, otherwise lane B. If both lanes are faulted, the port reports link down.

Top module: `lane_pair_mode_ctrl`

## Requirements
- R1: Out of reset, `strap_valid_o`=0, `mode_o`=1, `err_o`=0, `even_width_o`=2'b00 and `odd_up_o`=0. `mode_o` is 1 for two single-lane ports and 0 for one four-lane port on the even side.
- R2: The strap is sampled from the first clock edge after reset release. `strap_valid_o` rises at the edge that takes the STRAP_HOLD-th consecutive equal sample. At that edge `strap_width_o` and `mode_o` take the strap level: high selects two single-lane ports, low selects four lanes.
- R3: If the strap changes level before it has latched, the count of equal samples restarts at one.
- R4: Once the strap has latched, changes on `strap_i` affect neither `strap_width_o` nor `mode_o`.
- R5: A write that asks for a mode different from the programmed one is accepted only if both power-down bits were already set before the write. `mode_o` then keeps its value until a later (or the same) write clears either power-down bit, and at that write it takes the programmed mode.
- R6: A mode-changing write made while either power-down bit is clear is ignored for the mode, and it sets `err_o`. `err_o` stays set until `err_clr_i` is pulsed. The power-down bits are written by every write.
- R7: In four-lane mode with all lanes healthy and the even port powered, `even_width_o`=2'b10 (four lanes) and `even_route_o`=2'b10 (all lanes). The odd port is down: `pd_odd_o`=1 and `odd_up_o`=0.
- R8: In four-lane mode with any lane faulted, `even_width_o`=2'b01 (one lane). `even_route_o` is 2'b00 (lane A, `lane_fault_i[0]`) if lane A is healthy, otherwise 2'b01 (lane B, `lane_fault_i[1]`) if lane B is healthy. If both are faulted, `even_width_o`=2'b00 (link down).
- R9: In single-lane-pair mode the even port is routed to lane A (2'b00) and is down if lane A is faulted. `odd_up_o` is 1 only when lane B is healthy and the odd port is powered.
- R10: While the even power-down bit is set, or before the strap has latched, `even_width_o`=2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| strap_i | input | 1 | Board strap: 1 two single-lane ports, 0 four-lane |
| wr_en_i | input | 1 | Register write strobe |
| wr_mode_i | input | 1 | Written mode field (same encoding as `mode_o`) |
| wr_pd_wide_i | input | 1 | Written power-down bit for the even port |
| wr_pd_narrow_i | input | 1 | Written power-down bit for the odd port |
| err_clr_i | input | 1 | Clears the rejected-write flag |
| lane_fault_i | input | NLANES | Per-lane fault flags, bit 0 lane A, bit 1 lane B |
| strap_valid_o | output | 1 | Strap has been latched |
| strap_width_o | output | 1 | Latched strap level (width status) |
| mode_o | output | 1 | Effective mode |
| even_width_o | output | 2 | Even port width: 00 down, 01 one lane, 10 four lanes |
| even_route_o | output | 2 | Even port lane select: 00 A, 01 B, 10 all |
| odd_up_o | output | 1 | Odd port active on lane B |
| pd_even_o | output | 1 | Even port power-down |
| pd_odd_o | output | 1 | Odd port power-down (forced in four-lane mode) |
| err_o | output | 1 | Sticky rejected mode-write flag |

## Verification
The bench builds the block with its default values: STRAP_HOLD=10 and NLANES=4. With the full ten-cycle window, the bench can drop a strap change into the middle of the count and watch the latch move by exactly the restart amount. With four lanes, a fault on a lane outside the A/B pair is enough to force the downgrade, which separates the "any lane faulted" condition from the choice of fallback lane.

// File: rtl/lane_pair_mode_ctrl.sv
module lane_pair_mode_ctrl #(
  parameter int STRAP_HOLD = 10,
  parameter int NLANES     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_i,
  input  logic              wr_en_i,
  input  logic              wr_mode_i,
  input  logic              wr_pd_wide_i,
  input  logic              wr_pd_narrow_i,
  input  logic              err_clr_i,
  input  logic [NLANES-1:0] lane_fault_i,
  output logic              strap_valid_o,
  output logic              strap_width_o,
  output logic              mode_o,
  output logic [1:0]        even_width_o,
  output logic [1:0]        even_route_o,
  output logic              odd_up_o,
  output logic              pd_even_o,
  output logic              pd_odd_o,
  output logic              err_o
);
  localparam int CW = $clog2(STRAP_HOLD + 1);

  logic [CW-1:0] cnt_q;
  logic strap_q, valid_q, lat_q, tgt_q, act_q, pdw_q, pdn_q, err_q;

  wire both_pd = pdw_q & pdn_q;
  wire chg     = wr_en_i & (wr_mode_i != tgt_q);
  wire ok      = chg & both_pd & valid_q;
  wire bad     = chg & ~ok;
  wire pwr_up  = wr_en_i & both_pd & ~(wr_pd_wide_i & wr_pd_narrow_i);
  wire [CW-1:0] cnt_nx = (cnt_q == '0 || strap_i != strap_q) ? CW'(1) : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; strap_q <= 1'b0; valid_q <= 1'b0; lat_q <= 1'b0;
      tgt_q <= 1'b1; act_q <= 1'b1; pdw_q <= 1'b0; pdn_q <= 1'b0; err_q <= 1'b0;
    end else begin
      if (!valid_q) begin
        strap_q <= strap_i;
        cnt_q   <= cnt_nx;
        if (cnt_nx == CW'(STRAP_HOLD)) begin
          valid_q <= 1'b1;
          lat_q   <= strap_i;
          tgt_q   <= strap_i;
          act_q   <= strap_i;
        end
      end
      if (ok) tgt_q <= wr_mode_i;
      if (pwr_up) act_q <= ok ? wr_mode_i : tgt_q;
      if (wr_en_i) begin
        pdw_q <= wr_pd_wide_i;
        pdn_q <= wr_pd_narrow_i;
      end
      if (bad) err_q <= 1'b1;
      else if (err_clr_i) err_q <= 1'b0;
    end
  end

  wire all_ok = ~|lane_fault_i;
  wire a_ok   = ~lane_fault_i[0];
  wire b_ok   = ~lane_fault_i[1];

  always_comb begin
    even_width_o = 2'b00;
    even_route_o = 2'b00;
    if (valid_q && !pdw_q) begin
      if (act_q) begin
        even_width_o = a_ok ? 2'b01 : 2'b00;
      end else if (all_ok) begin
        even_width_o = 2'b10;
        even_route_o = 2'b10;
      end else if (a_ok) begin
        even_width_o = 2'b01;
      end else if (b_ok) begin
        even_width_o = 2'b01;
        even_route_o = 2'b01;
      end
    end
  end

  assign strap_valid_o = valid_q;
  assign strap_width_o = lat_q;
  assign mode_o        = act_q;
  assign odd_up_o      = valid_q & act_q & ~pdn_q & b_ok;
  assign pd_even_o     = pdw_q;
  assign pd_odd_o      = pdn_q | ~act_q;
  assign err_o         = err_q;

  assert_latch_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strap_valid_o) |-> (strap_width_o == $past(strap_i) && mode_o == $past(strap_i)));

  assert_strap_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strap_valid_o) |-> $stable(strap_width_o));

  assert_mode_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(strap_valid_o) && mode_o != $past(mode_o)) |-> $past(pd_even_o && pdn_q));

  assert_err_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> $past(wr_en_i));

  assert_quad_odd_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_valid_o && !mode_o) |-> (pd_odd_o && !odd_up_o));

  assert_full_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_valid_o && !mode_o && !pd_even_o && lane_fault_i == '0) |-> even_width_o == 2'b10);
endmodule

// File: tb/sim_lane_pair_mode_ctrl.sv
`timescale 1ns/1ps
module sim_lane_pair_mode_ctrl;
  localparam int HOLD = 10;
  localparam int NL   = 4;

  logic clk = 1'b0, rst_n = 1'b0, strap = 1'b0;
  logic wr_en = 1'b0, wr_mode = 1'b0, wr_pw = 1'b0, wr_pn = 1'b0, err_clr = 1'b0;
  logic [NL-1:0] fault = '0;
  logic sv, sw, mode, odd, pde, pdo, err;
  logic [1:0] wid, rt;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lane_pair_mode_ctrl #(.STRAP_HOLD(HOLD), .NLANES(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .wr_en_i(wr_en), .wr_mode_i(wr_mode),
    .wr_pd_wide_i(wr_pw), .wr_pd_narrow_i(wr_pn), .err_clr_i(err_clr), .lane_fault_i(fault),
    .strap_valid_o(sv), .strap_width_o(sw), .mode_o(mode), .even_width_o(wid),
    .even_route_o(rt), .odd_up_o(odd), .pd_even_o(pde), .pd_odd_o(pdo), .err_o(err));

  typedef struct { string req; logic [9:0] v; } exp_t;
  exp_t q[$];

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      logic [9:0] act;
      e = q.pop_front();
      act = {sv, sw, mode, wid, rt, odd, pdo, err};
      checks++;
      if (act !== e.v) begin
        fails++;
        $display("FAIL %s actual=%b expected=%b (sv sw mode wid rt odd pdo err)", e.req, act, e.v);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_out(string req, logic v_sv, logic v_sw, logic v_mode, logic [1:0] v_wid,
                            logic [1:0] v_rt, logic v_odd, logic v_pdo, logic v_err);
    exp_t e;
    e.req = req;
    e.v = {v_sv, v_sw, v_mode, v_wid, v_rt, v_odd, v_pdo, v_err};
    q.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic wr(logic m, logic pw, logic pn);
    wr_en = 1'b1; wr_mode = m; wr_pw = pw; wr_pn = pn;
    tick(1);
    wr_en = 1'b0;
  endtask

  initial begin
    tick(2);
    expect_out("R1 reset state", 0, 0, 1, 2'b00, 2'b00, 0, 0, 0);
    rst_n = 1'b1;
    tick(9);
    expect_out("R2 not latched after 9 edges", 0, 0, 1, 2'b00, 2'b00, 0, 0, 0);
    tick(1);
    expect_out("R2 R7 latched low strap, four lanes", 1, 0, 0, 2'b10, 2'b10, 0, 1, 0);

    rst_n = 1'b0; strap = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(5);
    strap = 1'b1;
    tick(9);
    expect_out("R3 count restarted by strap change", 0, 0, 1, 2'b00, 2'b00, 0, 0, 0);
    tick(1);
    expect_out("R3 R2 latched high strap", 1, 1, 1, 2'b01, 2'b00, 1, 0, 0);

    fault = 4'b0010;
    expect_out("R9 lane B fault drops odd port", 1, 1, 1, 2'b01, 2'b00, 0, 0, 0);
    fault = 4'b0001;
    expect_out("R9 lane A fault drops even port", 1, 1, 1, 2'b00, 2'b00, 1, 0, 0);
    fault = '0;

    strap = 1'b0;
    tick(3);
    expect_out("R4 strap change after latch ignored", 1, 1, 1, 2'b01, 2'b00, 1, 0, 0);

    wr(0, 0, 0);
    expect_out("R6 mode write while powered rejected", 1, 1, 1, 2'b01, 2'b00, 1, 0, 1);
    wr(1, 1, 1);
    expect_out("R6 R10 err sticky, both powered down", 1, 1, 1, 2'b00, 2'b00, 0, 1, 1);
    err_clr = 1'b1;
    tick(1);
    err_clr = 1'b0;
    expect_out("R6 err cleared", 1, 1, 1, 2'b00, 2'b00, 0, 1, 0);

    wr(0, 1, 1);
    expect_out("R5 accepted, mode held while down", 1, 1, 1, 2'b00, 2'b00, 0, 1, 0);
    wr(0, 0, 0);
    expect_out("R5 R7 power up applies four lanes", 1, 1, 0, 2'b10, 2'b10, 0, 1, 0);

    fault = 4'b0100;
    expect_out("R8 fault outside A/B falls back to A", 1, 1, 0, 2'b01, 2'b00, 0, 1, 0);
    fault = 4'b0101;
    expect_out("R8 lane A faulted falls back to B", 1, 1, 0, 2'b01, 2'b01, 0, 1, 0);
    fault = 4'b0011;
    expect_out("R8 both A and B faulted link down", 1, 1, 0, 2'b00, 2'b00, 0, 1, 0);
    fault = '0;

    wr(0, 1, 0);
    expect_out("R10 even power-down forces width 0", 1, 1, 0, 2'b00, 2'b00, 0, 1, 0);
    wr(1, 1, 0);
    expect_out("R6 partial power-down rejects mode change", 1, 1, 0, 2'b00, 2'b00, 0, 1, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000ns;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule